// File: doc/BRIEF.md
# UART FIFO Trigger and Ready Control

This block holds the receive and transmit byte FIFOs of one UART channel together with the control register that governs them. A single control byte enables both FIFOs, flushes either one through a self-clearing bit, turns on the multi-character DMA handshake mode, and picks the receive and transmit thresholds from two-bit codes. Four optional level registers (receive level, transmit level, flow-high, flow-low) can take over: as soon as any of them is nonzero, the receive and transmit thresholds are read directly from the receive-level and transmit-level registers.

The serial side and the host side exchange bytes through push and pop strobes on each FIFO. Two active-low outputs carry the DMA handshake. In the multi-character mode, receive-ready is asserted once the receive occupancy reaches its threshold or a receive timeout is signalled, and it stays asserted until the FIFO drains. Transmit-ready is asserted once the free space reaches its threshold and stays asserted until the FIFO is full. Outside that mode, the outputs follow simple occupancy rules. Pushes to a full FIFO and pops from an empty one are dropped and reported by one-cycle flags.

Control byte layout: bit 0 enables the FIFOs, bit 1 flushes the receive FIFO, bit 2 flushes the transmit FIFO, bit 3 selects the DMA mode, bits [5:4] hold the transmit code and bits [7:6] hold the receive code. Level register select: 0 receive level, 1 transmit level, 2 flow-high, 3 flow-low.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: Two clock cycles after reset is released, both counts are 0, the FIFOs are disabled, the multi-character mode is off, rx_rdy_n is 1, tx_rdy_n is 0, and all four error flags are 0.
- R2: While control bit 0 is 0, both FIFOs are held empty. Pushes and pops have no effect and raise no flag. A write that sets bit 0 takes effect from the next clock edge.
- R3: Each FIFO returns bytes in push order on its head output. Its count rises by one on an accepted push and falls by one on an accepted pop. A push and a pop in the same cycle leave the count unchanged.
- R4: A push to a FIFO holding 32 bytes and a pop from an empty FIFO are ignored. In the following cycle, the matching overflow or underflow flag is 1 for exactly one cycle.
- R5: A control write with bit 1 set leaves the receive FIFO empty after that edge, even when a receive push arrives in the same cycle. The transmit FIFO is not affected.
- R6: A control write with bit 2 set leaves the transmit FIFO empty after that edge, even when a transmit push arrives in the same cycle. The receive FIFO is not affected.
- R7: When all level registers are zero, receive codes 00/01/10/11 in bits [7:6] select thresholds of 8/16/24/28 bytes.
- R8: When all level registers are zero, transmit codes 00/01/10/11 in bits [5:4] select free-space thresholds of 16/8/24/30 bytes.
- R9: When any of the four level registers is nonzero, the receive threshold equals the receive-level register and the transmit threshold equals the transmit-level register.
- R10: With bits 0 and 3 set, rx_rdy_n falls in the cycle in which the receive count is nonzero and has reached the threshold, or in which rx_timeout is 1 while the count is nonzero. It then stays 0 until the receive count is 0.
- R11: With bits 0 and 3 set, tx_rdy_n falls in the cycle in which the free transmit space (32 minus count) reaches the threshold while the FIFO is not full. It then stays 0 until the transmit FIFO holds 32 bytes, where it is 1.
- R12: When bit 0 or bit 3 is 0, rx_rdy_n is 0 exactly when the receive count is nonzero, and tx_rdy_n is 0 exactly when the transmit count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte |
| lvl_wr | input | 1 | Write strobe for a level register |
| lvl_sel | input | 2 | Level register select |
| lvl_wdata | input | 8 | Level register value |
| rx_push | input | 1 | Push a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Pop the receive head |
| rx_head | output | 8 | Oldest receive byte |
| tx_push | input | 1 | Push a byte for transmission |
| tx_push_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Pop the transmit head |
| tx_head | output | 8 | Oldest transmit byte |
| rx_timeout | input | 1 | Receive timeout event |
| rx_count | output | 6 | Receive occupancy |
| tx_count | output | 6 | Transmit occupancy |
| rx_rdy_n | output | 1 | Receive DMA ready, active low |
| tx_rdy_n | output | 1 | Transmit DMA ready, active low |
| rx_ovf | output | 1 | Receive push dropped last cycle |
| rx_udf | output | 1 | Receive pop dropped last cycle |
| tx_ovf | output | 1 | Transmit push dropped last cycle |
| tx_udf | output | 1 | Transmit pop dropped last cycle |

## Verification
Two collisions matter most. The first is a flush write landing in the same cycle as a push to the FIFO being flushed. The bench provokes it directly and also lets the random phase issue flush writes while pushes run, and it expects the flush to win with the other FIFO untouched. The second is a threshold crossing or timeout coinciding with the push or pop that empties or fills the FIFO. Here, a reference model in the bench recomputes the held ready state from the pre-edge count every cycle and compares both ready outputs after each edge.

// File: rtl/uftc_pkg.sv
package uftc_pkg;

  typedef struct packed {
    logic       fifo_en;
    logic       dma_multi;
    logic [1:0] rx_code;
    logic [1:0] tx_code;
  } uftc_ctl_t;

  function automatic logic [7:0] rx_code_level(input logic [1:0] code);
    logic [7:0] lvl;
    case (code)
      2'd0:    lvl = 8'd8;
      2'd1:    lvl = 8'd16;
      2'd2:    lvl = 8'd24;
      default: lvl = 8'd28;
    endcase
    return lvl;
  endfunction

  function automatic logic [7:0] tx_code_level(input logic [1:0] code);
    logic [7:0] lvl;
    case (code)
      2'd0:    lvl = 8'd16;
      2'd1:    lvl = 8'd8;
      2'd2:    lvl = 8'd24;
      default: lvl = 8'd30;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/uftc_fifo.sv
module uftc_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          udf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          full, empty, do_push, do_pop;

  always_comb begin
    full     = (cnt_q == FULL);
    empty    = (cnt_q == '0);
    do_push  = push && !full && !flush;
    do_pop   = pop && !empty && !flush;
    ovf_d    = push && full && !flush;
    udf_d    = pop && empty && !flush;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
      udf_q    <= udf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;
  assign udf   = udf_q;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  assert_push_pop_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush && !full && !empty) |=> $stable(count));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full && !flush) |=> (ovf && count == FULL));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !flush) |=> (udf && count == '0));
  assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !ovf && !udf));

endmodule

// File: rtl/uftc_trig_sel.sv
module uftc_trig_sel #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_wr,
  input  logic [1:0]    lvl_sel,
  input  logic [LW-1:0] lvl_wdata,
  input  logic [1:0]    rx_code,
  input  logic [1:0]    tx_code,
  output logic [LW-1:0] rx_trig,
  output logic [LW-1:0] tx_trig
);
  import uftc_pkg::*;
  localparam int NREG = 4;

  logic [LW-1:0] lvl_q [NREG];
  logic [NREG-1:0] nz;
  logic            override;

  for (genvar i = 0; i < NREG; i++) begin : g_lvl
    logic [LW-1:0] lvl_d;
    logic          we;
    always_comb begin
      we    = lvl_wr && (lvl_sel == 2'(i));
      lvl_d = we ? lvl_wdata : lvl_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= '0;
      else        lvl_q[i] <= lvl_d;
    end
    assign nz[i] = |lvl_q[i];
  end

  always_comb begin
    override = |nz;
    if (override) begin
      rx_trig = lvl_q[0];
      tx_trig = lvl_q[1];
    end else begin
      rx_trig = LW'(rx_code_level(rx_code));
      tx_trig = LW'(tx_code_level(tx_code));
    end
  end

  assert_override_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_wr && lvl_sel == 2'd0 && lvl_wdata != '0) |=> (rx_trig == $past(lvl_wdata)));

endmodule

// File: rtl/uftc_rdy_ctrl.sv
module uftc_rdy_ctrl #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int LW    = 8,
  parameter bit IS_TX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          multi,
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] trig,
  input  logic          kick,
  output logic          rdy_n
);
  logic hold_q, hold_d;
  logic lvl_met, at_release, idle_rdy_n, set_now, act_now;

  if (IS_TX) begin : g_tx
    logic [31:0] free;
    always_comb begin
      free       = 32'(DEPTH) - 32'(count);
      lvl_met    = free >= 32'(trig);
      at_release = (32'(count) == 32'(DEPTH));
      idle_rdy_n = (count != '0);
    end
  end else begin : g_rx
    always_comb begin
      lvl_met    = 32'(count) >= 32'(trig);
      at_release = (count == '0);
      idle_rdy_n = (count == '0);
    end
  end

  always_comb begin
    set_now = (lvl_met || kick) && !at_release;
    act_now = set_now || (hold_q && !at_release);
    hold_d  = multi && act_now;
    rdy_n   = multi ? !act_now : idle_rdy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  if (IS_TX) begin : g_tx_chk
    assert_tx_full_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && 32'(count) == 32'(DEPTH)) |-> rdy_n);
    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && !rdy_n) |=> (!multi || 32'(count) == 32'(DEPTH) || !rdy_n));
  end else begin : g_rx_chk
    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && !rdy_n) |=> (!multi || count == '0 || !rdy_n));
    assert_rx_empty_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> rdy_n);
  end

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          lvl_wr,
  input  logic [1:0]    lvl_sel,
  input  logic [LW-1:0] lvl_wdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_head,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_head,
  input  logic          rx_timeout,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n,
  output logic          rx_ovf,
  output logic          rx_udf,
  output logic          tx_ovf,
  output logic          tx_udf
);
  import uftc_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  uftc_ctl_t     ctl_q, ctl_d;
  logic          rx_flush, tx_flush, multi;
  logic [LW-1:0] rx_trig, tx_trig;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.fifo_en   = ctl_wdata[0];
      ctl_d.dma_multi = ctl_wdata[3];
      ctl_d.tx_code   = ctl_wdata[5:4];
      ctl_d.rx_code   = ctl_wdata[7:6];
    end
    rx_flush = (ctl_wr && ctl_wdata[1]) || !ctl_q.fifo_en;
    tx_flush = (ctl_wr && ctl_wdata[2]) || !ctl_q.fifo_en;
    multi    = ctl_q.fifo_en && ctl_q.dma_multi;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctl_q <= '0;
    else             ctl_q <= ctl_d;
  end

  uftc_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) rx_fifo_i (
    .clk(clk), .rst_n(rst_sync_n), .flush(rx_flush),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
    .head(rx_head), .count(rx_count), .ovf(rx_ovf), .udf(rx_udf)
  );

  uftc_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) tx_fifo_i (
    .clk(clk), .rst_n(rst_sync_n), .flush(tx_flush),
    .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
    .head(tx_head), .count(tx_count), .ovf(tx_ovf), .udf(tx_udf)
  );

  uftc_trig_sel #(.LW(LW)) trig_i (
    .clk(clk), .rst_n(rst_sync_n), .lvl_wr(lvl_wr), .lvl_sel(lvl_sel),
    .lvl_wdata(lvl_wdata), .rx_code(ctl_q.rx_code), .tx_code(ctl_q.tx_code),
    .rx_trig(rx_trig), .tx_trig(tx_trig)
  );

  uftc_rdy_ctrl #(.DEPTH(DEPTH), .CW(CW), .LW(LW), .IS_TX(1'b0)) rx_rdy_i (
    .clk(clk), .rst_n(rst_sync_n), .multi(multi), .count(rx_count),
    .trig(rx_trig), .kick(rx_timeout), .rdy_n(rx_rdy_n)
  );

  uftc_rdy_ctrl #(.DEPTH(DEPTH), .CW(CW), .LW(LW), .IS_TX(1'b1)) tx_rdy_i (
    .clk(clk), .rst_n(rst_sync_n), .multi(multi), .count(tx_count),
    .trig(tx_trig), .kick(1'b0), .rdy_n(tx_rdy_n)
  );

  assert_disabled_empty_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl_q.fifo_en |=> (rx_count == '0 && tx_count == '0));
  assert_tx_flush_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_wr && ctl_wdata[2]) |=> (tx_count == '0));
  assert_idle_rx_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!multi && rx_count != '0) |-> !rx_rdy_n);

endmodule

// File: tb/uart_fifo_trig_ctrl_tb_top.sv
module uart_fifo_trig_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       ctl_wr = 0, lvl_wr = 0, rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, rx_timeout = 0;
  logic [7:0] ctl_wdata = 0, lvl_wdata = 0, rx_push_data = 0, tx_push_data = 0;
  logic [1:0] lvl_sel = 0;
  logic [7:0] rx_head, tx_head;
  logic [5:0] rx_count, tx_count;
  logic       rx_rdy_n, tx_rdy_n, rx_ovf, rx_udf, tx_ovf, tx_udf;

  uart_fifo_trig_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .lvl_wr(lvl_wr), .lvl_sel(lvl_sel), .lvl_wdata(lvl_wdata),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_head(rx_head),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_head(tx_head),
    .rx_timeout(rx_timeout), .rx_count(rx_count), .tx_count(tx_count),
    .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n), .rx_ovf(rx_ovf), .rx_udf(rx_udf),
    .tx_ovf(tx_ovf), .tx_udf(tx_udf)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int  rxq[$], txq[$];
  bit  m_en = 0, m_dma = 0, m_rxh = 0, m_txh = 0;
  bit  [1:0] m_rxc = 0, m_txc = 0;
  int  m_lvl[4] = '{0, 0, 0, 0};
  bit  e_rxovf = 0, e_rxudf = 0, e_txovf = 0, e_txudf = 0;

  function automatic bit ovr();
    return (m_lvl[0] != 0) || (m_lvl[1] != 0) || (m_lvl[2] != 0) || (m_lvl[3] != 0);
  endfunction
  function automatic int rx_trig_m();
    int t[4] = '{8, 16, 24, 28};
    return ovr() ? m_lvl[0] : t[m_rxc];
  endfunction
  function automatic int tx_trig_m();
    int t[4] = '{16, 8, 24, 30};
    return ovr() ? m_lvl[1] : t[m_txc];
  endfunction
  function automatic bit rx_act(input int c, input bit to);
    bit s = ((c >= rx_trig_m()) || to) && (c != 0);
    return s || (m_rxh && c != 0);
  endfunction
  function automatic bit tx_act(input int c);
    bit s = ((32 - c) >= tx_trig_m()) && (c != 32);
    return s || (m_txh && c != 32);
  endfunction
  function automatic bit exp_rx_rdy_n(input bit to);
    return (m_en && m_dma) ? !rx_act(rxq.size(), to) : (rxq.size() == 0);
  endfunction
  function automatic bit exp_tx_rdy_n();
    return (m_en && m_dma) ? !tx_act(txq.size()) : (txq.size() != 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit cw, input logic [7:0] cd, input bit lw, input logic [1:0] ls,
                      input logic [7:0] ld, input bit rpu, input logic [7:0] rpd, input bit rpo,
                      input bit tpu, input logic [7:0] tpd, input bit tpo, input bit to);
    bit mode1, nrxh, ntxh, rflush, tflush;
    int rs, ts;
    @(negedge clk);
    ctl_wr = cw; ctl_wdata = cd; lvl_wr = lw; lvl_sel = ls; lvl_wdata = ld;
    rx_push = rpu; rx_push_data = rpd; rx_pop = rpo;
    tx_push = tpu; tx_push_data = tpd; tx_pop = tpo; rx_timeout = to;
    mode1 = m_en && m_dma;
    nrxh = mode1 && rx_act(rxq.size(), to);
    ntxh = mode1 && tx_act(txq.size());
    rflush = (cw && cd[1]) || !m_en;
    tflush = (cw && cd[2]) || !m_en;
    rs = rxq.size(); ts = txq.size();
    if (rflush) begin rxq.delete(); e_rxovf = 0; e_rxudf = 0; end
    else begin
      e_rxovf = rpu && rs == 32; e_rxudf = rpo && rs == 0;
      if (rpo && rs > 0) void'(rxq.pop_front());
      if (rpu && rs < 32) rxq.push_back(int'(rpd));
    end
    if (tflush) begin txq.delete(); e_txovf = 0; e_txudf = 0; end
    else begin
      e_txovf = tpu && ts == 32; e_txudf = tpo && ts == 0;
      if (tpo && ts > 0) void'(txq.pop_front());
      if (tpu && ts < 32) txq.push_back(int'(tpd));
    end
    if (lw) m_lvl[ls] = int'(ld);
    if (cw) begin m_en = cd[0]; m_dma = cd[3]; m_txc = cd[5:4]; m_rxc = cd[7:6]; end
    m_rxh = nrxh; m_txh = ntxh;
    @(posedge clk); #1;
    chk(rx_count == rxq.size(), "R3 rx_count", rx_count, rxq.size());
    chk(tx_count == txq.size(), "R3 tx_count", tx_count, txq.size());
    if (rxq.size() > 0) chk(rx_head == rxq[0], "R3 rx_head", rx_head, rxq[0]);
    if (txq.size() > 0) chk(tx_head == txq[0], "R3 tx_head", tx_head, txq[0]);
    chk({rx_ovf, rx_udf, tx_ovf, tx_udf} == {e_rxovf, e_rxudf, e_txovf, e_txudf}, "R4 flags",
        {rx_ovf, rx_udf, tx_ovf, tx_udf}, {e_rxovf, e_rxudf, e_txovf, e_txudf});
    chk(rx_rdy_n == exp_rx_rdy_n(to), (m_en && m_dma) ? "R10 rx_rdy_n" : "R12 rx_rdy_n",
        rx_rdy_n, exp_rx_rdy_n(to));
    chk(tx_rdy_n == exp_tx_rdy_n(), (m_en && m_dma) ? "R11 tx_rdy_n" : "R12 tx_rdy_n",
        tx_rdy_n, exp_tx_rdy_n());
  endtask

  task automatic idle();                 step(0,0,0,0,0, 0,0,0, 0,0,0, 0); endtask
  task automatic wctl(input logic [7:0] d); step(1,d,0,0,0, 0,0,0, 0,0,0, 0); endtask
  task automatic wlvl(input logic [1:0] s, input logic [7:0] d); step(0,0,1,s,d, 0,0,0, 0,0,0, 0); endtask
  task automatic rxpush(input logic [7:0] d); step(0,0,0,0,0, 1,d,0, 0,0,0, 0); endtask
  task automatic rxpop();                step(0,0,0,0,0, 0,0,1, 0,0,0, 0); endtask
  task automatic txpush(input logic [7:0] d); step(0,0,0,0,0, 0,0,0, 1,d,0, 0); endtask
  task automatic txpop();                step(0,0,0,0,0, 0,0,0, 0,0,1, 0); endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rx_count == 0 && tx_count == 0, "R1 counts", {rx_count, tx_count}, 0);
    chk(rx_rdy_n == 1, "R1 rx_rdy_n", rx_rdy_n, 1);
    chk(tx_rdy_n == 0, "R1 tx_rdy_n", tx_rdy_n, 0);
    chk({rx_ovf, rx_udf, tx_ovf, tx_udf} == 0, "R1 flags", {rx_ovf, rx_udf, tx_ovf, tx_udf}, 0);

    // R2 disabled FIFOs ignore traffic
    step(0,0,0,0,0, 1,8'h11,0, 1,8'h22,0, 0);
    chk(rx_count == 0 && tx_count == 0, "R2 push while disabled", rx_count, 0);
    step(0,0,0,0,0, 0,0,1, 0,0,1, 0);
    chk(!rx_udf && !tx_udf, "R2 pop while disabled", rx_udf, 0);

    // R3 ordering and simultaneous push/pop
    wctl(8'h01);
    rxpush(8'hA1); rxpush(8'hA2); rxpush(8'hA3);
    step(0,0,0,0,0, 1,8'hA4,1, 0,0,0, 0);
    chk(rx_count == 3 && rx_head == 8'hA2, "R3 push+pop", rx_head, 8'hA2);

    // R5 flush beats same-cycle push, tx untouched
    txpush(8'h5A);
    step(1,8'h03,0,0,0, 1,8'h77,0, 0,0,0, 0);
    chk(rx_count == 0, "R5 rx flush", rx_count, 0);
    chk(tx_count == 1, "R5 tx untouched", tx_count, 1);
    // R6
    rxpush(8'h31);
    step(1,8'h05,0,0,0, 0,0,0, 1,8'h66,0, 0);
    chk(tx_count == 0, "R6 tx flush", tx_count, 0);
    chk(rx_count == 1, "R6 rx untouched", rx_count, 1);

    // R4 overflow / underflow
    for (int i = 0; i < 32; i++) rxpush(8'(i));
    chk(rx_ovf == 1, "R4 rx overflow", rx_ovf, 1);
    idle();
    chk(rx_ovf == 0 && rx_count == 32, "R4 one-cycle flag", rx_ovf, 0);
    wctl(8'h03);
    rxpop();
    chk(rx_udf == 1, "R4 rx underflow", rx_udf, 1);

    // R7 receive coded thresholds
    for (int c = 0; c < 4; c++) begin
      int lv[4] = '{8, 16, 24, 28};
      wctl(8'(8'h0B | (c << 6)));
      for (int i = 0; i < lv[c] - 1; i++) rxpush(8'(i));
      chk(rx_rdy_n == 1, "R7 below rx level", rx_rdy_n, 1);
      rxpush(8'hEE);
      chk(rx_rdy_n == 0, "R7 at rx level", rx_rdy_n, 0);
      while (rx_count > 1) rxpop();
      chk(rx_rdy_n == 0, "R10 held until empty", rx_rdy_n, 0);
      rxpop();
      chk(rx_rdy_n == 1, "R10 released at empty", rx_rdy_n, 1);
    end

    // R8 transmit coded thresholds (free space)
    for (int c = 0; c < 4; c++) begin
      int lv[4] = '{16, 8, 24, 30};
      wctl(8'(8'h0D | (c << 4)));
      chk(tx_rdy_n == 0, "R8 empty tx ready", tx_rdy_n, 0);
      for (int i = 0; i < 32; i++) txpush(8'(i));
      chk(tx_rdy_n == 1, "R11 full tx", tx_rdy_n, 1);
      while (32 - tx_count < lv[c] - 1) txpop();
      chk(tx_rdy_n == 1, "R8 below tx level", tx_rdy_n, 1);
      txpop();
      chk(tx_rdy_n == 0, "R8 at tx level", tx_rdy_n, 0);
    end

    // R10 timeout
    wctl(8'h0B);
    rxpush(8'h01); rxpush(8'h02);
    chk(rx_rdy_n == 1, "R10 below level", rx_rdy_n, 1);
    step(0,0,0,0,0, 0,0,0, 0,0,0, 1);
    chk(rx_rdy_n == 0, "R10 timeout", rx_rdy_n, 0);
    idle();
    chk(rx_rdy_n == 0, "R10 timeout held", rx_rdy_n, 0);
    rxpop(); rxpop();
    chk(rx_rdy_n == 1, "R10 release", rx_rdy_n, 1);

    // R9 override
    wlvl(2'd0, 8'd5);
    for (int i = 0; i < 4; i++) rxpush(8'(i));
    chk(rx_rdy_n == 1, "R9 below override", rx_rdy_n, 1);
    rxpush(8'h44);
    chk(rx_rdy_n == 0, "R9 at override", rx_rdy_n, 0);
    wctl(8'h0F);
    wlvl(2'd0, 8'd0);
    wlvl(2'd3, 8'd1);
    rxpush(8'h99);
    chk(rx_rdy_n == 0, "R9 flow reg enables override", rx_rdy_n, 0);
    wlvl(2'd3, 8'd0);

    // R12 idle mode
    wctl(8'h07);
    chk(rx_rdy_n == 1 && tx_rdy_n == 0, "R12 empty", {rx_rdy_n, tx_rdy_n}, 2'b10);
    rxpush(8'h12); txpush(8'h34);
    chk(rx_rdy_n == 0 && tx_rdy_n == 1, "R12 nonempty", {rx_rdy_n, tx_rdy_n}, 2'b01);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit cw = ($urandom_range(0, 39) == 0);
      logic [7:0] cd = 8'($urandom);
      bit lw = ($urandom_range(0, 79) == 0);
      logic [7:0] ld = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(0, 34));
      int bias = (n / 300) % 2;
      if (cw) begin
        cd[0] = ($urandom_range(0, 9) != 0);
        if ($urandom_range(0, 3) != 0) cd[2:1] = 2'b00;
      end
      step(cw, cd, lw, 2'($urandom), ld,
           $urandom_range(0, 9) < (bias ? 7 : 3), 8'($urandom), $urandom_range(0, 9) < (bias ? 3 : 7),
           $urandom_range(0, 9) < (bias ? 3 : 7), 8'($urandom), $urandom_range(0, 9) < (bias ? 7 : 3),
           $urandom_range(0, 19) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule